// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single-word requests from a small 8-bit processor core into external bus cycles. The bus shares one 8-bit path between the low address byte and the data, and a few dedicated lines carry the upper address bits. The core starts a cycle with a one-clock start pulse that carries the address, the write data, the direction and an opcode-fetch flag. When the cycle ends the block returns a one-clock done pulse. A read also returns the data it captured.

Every cycle takes exactly five clocks. On clocks 0 and 1 the address strobe is high and the low address byte is on the shared bus. Clock 2 turns the bus around. On clocks 3 and 4 the data strobe is high. The read/write line and the upper address lines hold their value for the whole cycle. The opcode-fetch indicator covers the whole of a fetch cycle, so it overlaps the data strobe. A bundled address latch captures the low byte while the address strobe is high, so that a consumer can recover the full address during the data phase. A low-power hold input suppresses all strobe activity. Reset is synchronous and active high.

Top module: `mux_bus_seq`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `as_o`, `ds_o`, `li_o`, `bus_oe`, `done` and `addr_hi` are 0, `rw_o` is 1 and `rdata` is 0.
- R2: A `start` accepted at clock edge E begins clock 0 of a cycle. On clocks 0 and 1 after E, `as_o` is 1, `bus_oe` is 1 and `bus_out` equals address bits [7:0]. On all five clocks, `addr_hi` equals address bits [12:8].
- R3: On clock 2 both strobes are 0. On a read, `bus_oe` is 0 on clocks 2 to 4. On a write, `bus_oe` is 1 and `bus_out` equals the write data on clocks 2 to 4.
- R4: `ds_o` is 1 on clocks 3 and 4 only. `rw_o` is 1 for a read and 0 for a write on all five clocks, so it never changes on the clock where `ds_o` rises.
- R5: `li_o` is 1 on all five clocks of a cycle whose fetch flag is set, and 0 otherwise.
- R6: `done` is 1 for exactly one clock, the clock that follows clock 4. After a read, `rdata` holds the `bus_in` value present on clock 4. A write leaves `rdata` unchanged.
- R7: A `start` seen while a cycle is on clocks 0 to 3 is ignored. A `start` seen on clock 4 begins the next cycle immediately, so the strobes repeat every five clocks.
- R8: While `halt` is 1, no `start` is accepted. Any cycle in progress is dropped without a `done`, and from the next clock `as_o`, `ds_o`, `li_o` and `bus_oe` are 0.
- R9: With no cycle in progress, both strobes and `bus_oe` are 0.
- R10: `lat_lo` takes the value on the shared bus while `as_o` is 1 and then holds it. From clock 1 to the end of the cycle it equals address bits [7:0], even while write data is on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Low-power hold; suppresses strobes |
| start | input | 1 | One-clock request pulse |
| req_addr | input | 13 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an opcode fetch |
| done | output | 1 | End-of-cycle pulse |
| rdata | output | 8 | Captured read data |
| as_o | output | 1 | Address strobe |
| ds_o | output | 1 | Data strobe |
| rw_o | output | 1 | High = read, low = write |
| li_o | output | 1 | Opcode-fetch indicator |
| addr_hi | output | 5 | Non-multiplexed upper address |
| bus_out | output | 8 | Shared bus drive value |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_in | input | 8 | Shared bus sampled value |
| lat_lo | output | 8 | Recovered low address byte |

## Verification
The bench uses the default build: 13 address bits, 8 data bits, a five-clock cycle with two address clocks and one turnaround clock. This is small enough that one sweep of 64 cycles reaches every mix of read, write and fetch. The address and data patterns come from arithmetic and vary across all upper-address codes. The bench checks every output on every clock of every cycle. Directed runs cover a start arriving in each busy clock, the back-to-back start on clock 4, a halt in the middle of a cycle and a start held during a halt.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int DEF_ADDR_W   = 13;
  localparam int DEF_DATA_W   = 8;
  localparam int DEF_CYC_LEN  = 5;
  localparam int DEF_AS_LEN   = 2;
  localparam int DEF_TURN_LEN = 1;

  function automatic int ph_width(input int cyc_len);
    return (cyc_len <= 2) ? 1 : $clog2(cyc_len);
  endfunction
endpackage

// File: rtl/bus_seq_phase.sv
module bus_seq_phase #(
  parameter int CYC_LEN = 5,
  parameter int PH_W    = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            halt,
  output logic            act,
  output logic [PH_W-1:0] ph,
  output logic            nxt_act,
  output logic [PH_W-1:0] nxt_ph,
  output logic            load,
  output logic            fin
);
  localparam logic [PH_W-1:0] LAST = PH_W'(CYC_LEN - 1);

  always_comb begin
    fin  = act && (ph == LAST) && !halt;
    load = !halt && start && (!act || ph == LAST);
    if (halt)      nxt_act = 1'b0;
    else if (load) nxt_act = 1'b1;
    else if (fin)  nxt_act = 1'b0;
    else           nxt_act = act;
    if (halt || load)              nxt_ph = '0;
    else if (act && ph != LAST)    nxt_ph = ph + 1'b1;
    else                           nxt_ph = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      ph  <= '0;
    end else begin
      act <= nxt_act;
      ph  <= nxt_ph;
    end
  end

  // R8
  halt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !act);
  // R7
  ph_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph <= LAST);
  // R7
  ph_step_chk: assert property (@(posedge clk) disable iff (rst)
    (act && ph != LAST && !halt) |=> (act && ph == $past(ph) + 1'b1));
endmodule

// File: rtl/bus_seq_drive.sv
module bus_seq_drive #(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int AS_LEN   = 2,
  parameter int TURN_LEN = 1,
  parameter int PH_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nxt_act,
  input  logic [PH_W-1:0]   nxt_ph,
  input  logic              load,
  input  logic              fin,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic [DATA_W-1:0] bus_in,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              as_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              li_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [PH_W-1:0] AS_END   = PH_W'(AS_LEN);
  localparam logic [PH_W-1:0] DS_START = PH_W'(AS_LEN + TURN_LEN);

  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata;
  logic              cap_write;
  logic              cap_fetch;

  logic [ADDR_W-1:0] n_addr;
  logic [DATA_W-1:0] n_wdata;
  logic              n_write;
  logic              n_fetch;
  logic              n_aph;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_addr  <= '0;
      cap_wdata <= '0;
      cap_write <= 1'b0;
      cap_fetch <= 1'b0;
    end else if (load) begin
      cap_addr  <= req_addr;
      cap_wdata <= req_wdata;
      cap_write <= req_write;
      cap_fetch <= req_fetch;
    end
  end

  always_comb begin
    n_addr  = load ? req_addr  : cap_addr;
    n_wdata = load ? req_wdata : cap_wdata;
    n_write = load ? req_write : cap_write;
    n_fetch = load ? req_fetch : cap_fetch;
    n_aph   = nxt_ph < AS_END;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      as_o    <= 1'b0;
      ds_o    <= 1'b0;
      rw_o    <= 1'b1;
      li_o    <= 1'b0;
      addr_hi <= '0;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      as_o    <= nxt_act && n_aph;
      ds_o    <= nxt_act && (nxt_ph >= DS_START);
      rw_o    <= nxt_act ? !n_write : 1'b1;
      li_o    <= nxt_act && n_fetch;
      addr_hi <= nxt_act ? n_addr[ADDR_W-1:DATA_W] : '0;
      bus_oe  <= nxt_act && (n_aph || n_write);
      if (!nxt_act)   bus_out <= '0;
      else if (n_aph) bus_out <= n_addr[DATA_W-1:0];
      else if (n_write) bus_out <= n_wdata;
      else            bus_out <= '0;
      done <= fin;
      if (fin && !cap_write) rdata <= bus_in;
    end
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(as_o && ds_o));
  // R4
  rw_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_o) |-> $stable(rw_o));
  // R3
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_o && rw_o) |-> !bus_oe);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R2
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ds_o && $past(ds_o)) |-> $stable(addr_hi));
  initial begin
    // R2
    hi_width_chk: assert (HI_W > 0);
  end
endmodule

// File: rtl/bus_seq_alatch.sv
module bus_seq_alatch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] bus_val,
  output logic [DATA_W-1:0] lat_lo
);
  always_ff @(posedge clk) begin
    if (rst)         lat_lo <= '0;
    else if (strobe) lat_lo <= bus_val;
  end

  // R10
  latch_take_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (lat_lo == $past(bus_val)));
  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> $stable(lat_lo));
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int CYC_LEN  = DEF_CYC_LEN,
  parameter int AS_LEN   = DEF_AS_LEN,
  parameter int TURN_LEN = DEF_TURN_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              as_o,
  output logic              ds_o,
  output logic              rw_o,
  output logic              li_o,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] lat_lo
);
  localparam int PH_W = ph_width(CYC_LEN);

  logic            act;
  logic [PH_W-1:0] ph;
  logic            nxt_act;
  logic [PH_W-1:0] nxt_ph;
  logic            load;
  logic            fin;
  logic [DATA_W-1:0] bus_val;

  bus_seq_phase #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .start(start), .halt(halt),
    .act(act), .ph(ph), .nxt_act(nxt_act), .nxt_ph(nxt_ph),
    .load(load), .fin(fin)
  );

  bus_seq_drive #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AS_LEN(AS_LEN),
    .TURN_LEN(TURN_LEN), .PH_W(PH_W)
  ) u_drive (
    .clk(clk), .rst(rst), .nxt_act(nxt_act), .nxt_ph(nxt_ph),
    .load(load), .fin(fin), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .req_fetch(req_fetch), .bus_in(bus_in),
    .done(done), .rdata(rdata), .as_o(as_o), .ds_o(ds_o), .rw_o(rw_o),
    .li_o(li_o), .addr_hi(addr_hi), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  assign bus_val = bus_oe ? bus_out : bus_in;

  bus_seq_alatch #(.DATA_W(DATA_W)) u_alatch (
    .clk(clk), .rst(rst), .strobe(as_o), .bus_val(bus_val), .lat_lo(lat_lo)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!act && !$past(act)) |-> (!as_o && !ds_o && !bus_oe));
endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic        start = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_fetch = 1'b0;
  logic        done;
  logic [7:0]  rdata;
  logic        as_o, ds_o, rw_o, li_o;
  logic [4:0]  addr_hi;
  logic [7:0]  bus_out;
  logic        bus_oe;
  logic [7:0]  bus_in = '0;
  logic [7:0]  lat_lo;

  int total = 0;
  int bad = 0;
  logic [7:0] last_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst(rst), .halt(halt), .start(start), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_fetch(req_fetch),
    .done(done), .rdata(rdata), .as_o(as_o), .ds_o(ds_o), .rw_o(rw_o),
    .li_o(li_o), .addr_hi(addr_hi), .bus_out(bus_out), .bus_oe(bus_oe),
    .bus_in(bus_in), .lat_lo(lat_lo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_phase(input int k, input logic [12:0] a, input logic [7:0] w,
                           input bit wr, input bit f);
    chk(as_o == (k < 2), "R2 as_o", as_o, k < 2);
    chk(ds_o == (k >= 3), "R4 ds_o", ds_o, k >= 3);
    chk(rw_o == !wr, "R4 rw_o", rw_o, !wr);
    chk(li_o == f, "R5 li_o", li_o, f);
    chk(addr_hi == a[12:8], "R2 addr_hi", addr_hi, a[12:8]);
    chk(bus_oe == (k < 2 || wr), "R3 bus_oe", bus_oe, (k < 2 || wr));
    if (k < 2) chk(bus_out == a[7:0], "R2 bus_out addr", bus_out, a[7:0]);
    else if (wr) chk(bus_out == w, "R3 bus_out wdata", bus_out, w);
    if (k >= 1) chk(lat_lo == a[7:0], "R10 lat_lo", lat_lo, a[7:0]);
    chk(done == 1'b0, "R6 done early", done, 0);
  endtask

  task automatic run_cycle(input logic [12:0] a, input logic [7:0] w, input bit wr,
                           input bit f, input logic [7:0] rd);
    req_addr = a; req_wdata = w; req_write = wr; req_fetch = f; start = 1'b1;
    bus_in = rd;
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      chk_phase(k, a, w, wr, f);
    end
    @(negedge clk);
    chk(done == 1'b1, "R6 done", done, 1);
    if (!wr) last_rd = rd;
    chk(rdata == last_rd, "R6 rdata", rdata, last_rd);
    chk(as_o == 1'b0 && bus_oe == 1'b0, "R9 idle after", {as_o, bus_oe}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({as_o, ds_o, li_o, bus_oe, done} == 5'b0, "R1 strobes in reset",
        {as_o, ds_o, li_o, bus_oe, done}, 0);
    chk(rw_o == 1'b1 && addr_hi == 5'd0, "R1 rw/addr_hi", {rw_o, addr_hi}, 6'h20);
    rst = 1'b0;
    @(negedge clk);
    chk({as_o, ds_o, li_o, bus_oe, done} == 5'b0 && rdata == 8'd0, "R1 after reset",
        {as_o, ds_o, li_o, bus_oe, done}, 0);
    chk(ds_o == 1'b0 && bus_oe == 1'b0, "R9 idle", {ds_o, bus_oe}, 0);

    // sweep over read/write/fetch mixes and arithmetic address/data patterns
    for (int i = 0; i < 64; i++) begin
      logic [12:0] a;
      logic [7:0]  w, rd;
      a  = 13'((i * 1237 + 5) ^ (i << 8));
      w  = 8'(i * 37 + 11);
      rd = 8'((i * 53) ^ 8'hA5);
      run_cycle(a, w, i[0], i[1], rd);
    end

    // R7: starts during busy clocks ignored, start on clock 4 chains
    req_addr = 13'h1A3C; req_wdata = 8'h00; req_write = 1'b0; req_fetch = 1'b1;
    start = 1'b1; bus_in = 8'h5E;
    @(posedge clk);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_phase(k, 13'h1A3C, 8'h00, 1'b0, 1'b1);
      req_addr = 13'h0471; req_wdata = 8'hC3; req_write = 1'b1; req_fetch = 1'b0;
      start = 1'b1;
    end
    @(negedge clk);
    chk(done == 1'b1, "R7 done of first", done, 1);
    chk(rdata == 8'h5E, "R7 rdata of first", rdata, 8'h5E);
    chk(as_o == 1'b1 && bus_out == 8'h71, "R7 back-to-back addr", bus_out, 8'h71);
    chk(addr_hi == 5'h04 && rw_o == 1'b0 && li_o == 1'b0, "R7 second cycle fields",
        {addr_hi, rw_o, li_o}, {5'h04, 2'b00});
    start = 1'b0;
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      chk_phase(k, 13'h0471, 8'hC3, 1'b1, 1'b0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R7 done of second", done, 1);
    chk(rdata == 8'h5E, "R6 rdata kept on write", rdata, 8'h5E);
    @(negedge clk);

    // R8: halt mid cycle, and start held during halt
    req_addr = 13'h0F0F; req_write = 1'b0; req_fetch = 1'b1; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    halt = 1'b1;
    @(negedge clk);
    chk({as_o, ds_o, li_o, bus_oe} == 4'b0, "R8 halt quiets bus",
        {as_o, ds_o, li_o, bus_oe}, 0);
    start = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk({as_o, ds_o, done} == 3'b0, "R8 no strobes while halted", {as_o, ds_o, done}, 0);
    end
    start = 1'b0; halt = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({as_o, ds_o, bus_oe, done} == 4'b0, "R9 idle after halt",
          {as_o, ds_o, bus_oe, done}, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule